// File: doc/BRIEF.md
# Toggle-Encoded Busy Relay

A busy condition has to travel over AC-coupled differential links, and such a link cannot hold a static level. This block therefore treats busy as activity: a link that keeps changing state means busy, and a link that holds still means not busy. Each of several incoming busy links goes through a two-stage synchroniser and an edge detector. The result feeds an activity detector with a programmable window, which recovers a clean busy level for that link.

The recovered levels are ORed into one merged busy, so the whole detector is stopped as soon as any single front end reports that it is full. In automatic mode the merged busy drives the fast outbound line as a toggle running at half the clock rate. The toggle freezes at its last value when busy drops. In any other mode the fast line carries an external trigger through unchanged. The recovered per-link levels and the merged level are also brought out as plain pins.

Top module: `busy_toggle_relay`

## Requirements
- R1: After reset, every per-link busy output, the merged busy output and the internal toggle state are 0.
- R2: A link's busy output goes to 1 when an input edge arrives no more than WINDOW clocks after the previous edge. Each input change passes a two-flop synchroniser and an edge stage. When the line changes before posedge A and again before posedge A+1, busy is visible after posedge A+3.
- R3: A lone edge never sets a link's busy output. Two edges whose input changes are more than WINDOW clocks apart do not set it either.
- R4: A busy link clears once WINDOW clocks pass with no edge. If the last input change precedes posedge A, busy is still 1 after posedge A+WINDOW+1 and is 0 after posedge A+WINDOW+2.
- R5: The merged busy output is 1 exactly when at least one per-link busy output is 1. Each link's busy is independent of activity on the other links.
- R6: With the mode pin at 1 (automatic) and merged busy at 1, the fast output inverts on every clock, which gives a square wave at half the clock rate.
- R7: With the mode pin at 1 and merged busy at 0, the fast output holds the value it last had.
- R8: With the mode pin at 0, the fast output equals the external trigger input combinationally, and busy recovery continues to work.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_line_i | input | N_LINKS | Asynchronous toggle-encoded busy links |
| auto_mode_i | input | 1 | 1 selects the busy toggle on the fast line, 0 the trigger |
| ext_trig_i | input | 1 | External trigger for non-automatic modes |
| link_busy_o | output | N_LINKS | Recovered busy level per link |
| busy_o | output | 1 | OR of all recovered link busy levels |
| fast_o | output | 1 | Fast outbound line |

## Verification
The bench builds the relay with N_LINKS = 8 and WINDOW = 6. The short window keeps each clear-down test to a few clocks, so the bench can probe both sides of the gap limit in a handful of cycles: a gap of exactly WINDOW sets busy and a gap of WINDOW+1 does not. It can also probe the exact clock on which busy clears. Eight links leave room for mixed patterns: single links, neighbouring pairs, all links, and handovers between links, each with the mode pin set either way.

// File: rtl/relay_pkg.sv
package relay_pkg;
  typedef enum logic {
    FAST_SRC_TRIG = 1'b0,
    FAST_SRC_BUSY = 1'b1
  } fast_src_e;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction
endpackage

// File: rtl/busy_activity_det.sv
module busy_activity_det #(
  parameter int unsigned WINDOW = 16,
  parameter int unsigned CNT_W  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic busy_o
);
  logic [2:0]       sync_q;
  logic             edge_w;
  logic [CNT_W-1:0] gap_q;
  logic             armed_q;
  logic             busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], line_i};
  end

  assign edge_w = sync_q[2] ^ sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q   <= '0;
      armed_q <= 1'b0;
      busy_q  <= 1'b0;
    end else if (edge_w) begin
      gap_q   <= '0;
      armed_q <= 1'b1;
      if (armed_q) busy_q <= 1'b1;
    end else if (armed_q) begin
      if (gap_q == CNT_W'(WINDOW - 1)) begin
        gap_q   <= '0;
        armed_q <= 1'b0;
        busy_q  <= 1'b0;
      end else begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;

  AST_BUSY_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(edge_w)); // R2
  AST_CLEAR_ON_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> !$past(edge_w)); // R4
  AST_NO_BUSY_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !busy_q); // R3
endmodule

// File: rtl/busy_toggle_enc.sv
module busy_toggle_enc (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  output logic tog_o
);
  logic tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tog_q <= 1'b0;
    else if (busy_i) tog_q <= ~tog_q;
  end

  assign tog_o = tog_q;

  AST_TOGGLE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> (tog_q != $past(tog_q))); // R6
  AST_TOGGLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |=> $stable(tog_q)); // R7
endmodule

// File: rtl/busy_toggle_relay.sv
module busy_toggle_relay
  import relay_pkg::*;
#(
  parameter int unsigned N_LINKS = 8,
  parameter int unsigned WINDOW  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINKS-1:0] busy_line_i,
  input  logic               auto_mode_i,
  input  logic               ext_trig_i,
  output logic [N_LINKS-1:0] link_busy_o,
  output logic               busy_o,
  output logic               fast_o
);
  localparam int unsigned CNT_W = cnt_width(WINDOW);

  logic [N_LINKS-1:0] link_busy_w;
  logic               merged_w;
  logic               tog_w;
  fast_src_e          src_w;

  for (genvar g = 0; g < N_LINKS; g++) begin : g_link
    busy_activity_det #(
      .WINDOW (WINDOW),
      .CNT_W  (CNT_W)
    ) u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (busy_line_i[g]),
      .busy_o (link_busy_w[g])
    );
  end

  assign merged_w = |link_busy_w;

  busy_toggle_enc u_enc (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy_i (merged_w),
    .tog_o  (tog_w)
  );

  assign src_w       = auto_mode_i ? FAST_SRC_BUSY : FAST_SRC_TRIG;
  assign fast_o      = (src_w == FAST_SRC_BUSY) ? tog_w : ext_trig_i;
  assign link_busy_o = link_busy_w;
  assign busy_o      = merged_w;

  AST_AUTO_FAST_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode_i && busy_o) ##1 auto_mode_i |-> (fast_o != $past(fast_o))); // R6
  AST_AUTO_FAST_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode_i && !busy_o) ##1 auto_mode_i |-> $stable(fast_o)); // R7
endmodule

// File: tb/sim_busy_toggle_relay.sv
`timescale 1ns/1ps
module sim_busy_toggle_relay;
  localparam int N = 8;
  localparam int W = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] lines = '0;
  logic         auto_mode = 1'b1;
  logic         trig = 1'b0;
  logic [N-1:0] link_busy;
  logic         busy;
  logic         fast;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  busy_toggle_relay #(.N_LINKS(N), .WINDOW(W)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_line_i (lines),
    .auto_mode_i (auto_mode),
    .ext_trig_i  (trig),
    .link_busy_o (link_busy),
    .busy_o      (busy),
    .fast_o      (fast)
  );

  // {mask[7:0], auto, trig}
  localparam logic [9:0] VEC [8] = '{
    {8'h01, 1'b1, 1'b0},
    {8'h80, 1'b1, 1'b1},
    {8'h18, 1'b1, 1'b0},
    {8'h00, 1'b1, 1'b1},
    {8'hFF, 1'b1, 1'b0},
    {8'h24, 1'b0, 1'b1},
    {8'h00, 1'b0, 1'b0},
    {8'h42, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic f1;
    logic f2;
    repeat (3) @(negedge clk);
    chk("R1 link busy", 32'(link_busy), 0);
    chk("R1 merged busy", 32'(busy), 0);
    chk("R1 fast toggle", 32'(fast), 0);
    rst_n = 1'b1;
    idle(4);
    chk("R1 idle after release", 32'(busy), 0);

    for (int i = 0; i < 8; i++) begin
      logic [7:0] m;
      m = VEC[i][9:2];
      auto_mode = VEC[i][1];
      trig = VEC[i][0];
      for (int c = 0; c < 30; c++) begin
        @(negedge clk);
        lines = lines ^ m;
      end
      @(negedge clk);
      f1 = fast;
      lines = lines ^ m;
      chk("R2 R3 R5 link busy", 32'(link_busy), 32'(m));
      chk("R5 merged busy", 32'(busy), 32'(|m));
      @(negedge clk);
      f2 = fast;
      lines = lines ^ m;
      if (!VEC[i][1]) chk("R8 trigger passthrough", 32'(f2), 32'(VEC[i][0]));
      else if (|m)    chk("R6 half-rate toggle", 32'(f2 != f1), 1);
      else            chk("R7 hold last value", 32'(f2 == f1), 1);
    end
    idle(W + 6);
    chk("R4 all clear", 32'(busy), 0);

    // R8: trigger follows immediately while a link is busy
    auto_mode = 1'b0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      lines[3] = ~lines[3];
      trig = c[0];
      #1;
      if (c > 5) chk("R8 trig while busy", 32'(fast), 32'(c[0]));
    end
    chk("R8 busy still recovered", 32'(busy), 1);
    auto_mode = 1'b1;
    idle(W + 6);

    // R2 / R4 exact latency on link 0
    lines[0] = ~lines[0];
    @(negedge clk);
    lines[0] = ~lines[0];
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R2 not yet busy", 32'(link_busy[0]), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R2 busy on second edge", 32'(link_busy[0]), 1);
    repeat (W - 1) @(posedge clk);
    @(negedge clk);
    chk("R4 still busy at window end", 32'(link_busy[0]), 1);
    @(posedge clk);
    @(negedge clk);
    chk("R4 cleared after window", 32'(link_busy[0]), 0);
    idle(W + 4);

    // R3 gap boundaries on link 1
    for (int k = W; k <= W + 1; k++) begin
      lines[1] = ~lines[1];
      repeat (k) @(negedge clk);
      lines[1] = ~lines[1];
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk((k == W) ? "R2 gap equal to window" : "R3 gap beyond window",
          32'(link_busy[1]), 32'(k == W));
      idle(W + 6);
    end

    // R3 lone edge
    lines[2] = ~lines[2];
    idle(W + 8);
    chk("R3 lone edge", 32'(link_busy[2]), 0);
    chk("R5 other links untouched", 32'(busy), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule